// File: doc/BRIEF.md
# Multiprocessor-Format Serial Receiver with Address Wake-Up

This block receives asynchronous serial characters in which one extra flag bit follows the data bits, where a parity bit would otherwise sit. The flag tells the receiver whether the character is a station address (flag 1) or ordinary data (flag 0). Each completed character is written to a receive buffer. A receive-full flag, a framing-error flag and an overrun flag report its state, and the received flag bit is latched next to the data so software can tell addresses from data.

A sleep mode lets a station that was not addressed skip traffic without software work. Once software arms it, every data character is dropped silently: the buffer is not written, no error is detected and no status flag moves. The first address character ends the mode by itself. That character is then received normally, so software can compare it against its own station number and re-arm sleep if it does not match.

The line is oversampled by an external tick at sixteen times the bit rate. The receiver holds no baud generator, transmitter or address comparator.

Top module: `mpuart_rx`

## Requirements
- R1: A frame is a low start bit, then 8 data bits (len8_i=1) or 7 data bits (len8_i=0) least-significant bit first, then the flag bit, then one stop bit. Every bit lasts 16 ticks. After two cycles of input synchronisation, the start bit is confirmed on the 8th tick and each later bit is sampled 16 ticks after the previous one. Status updates on the clock edge after the stop-bit sample. With tick_i high on every cycle, this is 16*n+44 cycles after the line first goes low, where n is the data length. In 7-bit mode data_o[7] reads 0.
- R2: While sleep is off, every completed character that finds the buffer free (or freed on the same edge) is written to data_o. It sets full_o and copies its flag bit to mpb_o, whatever the flag value. full_o rises only on such a load.
- R3: While sleep is on, a character with flag 0 leaves data_o, mpb_o, full_o, fer_o and ore_o unchanged, apart from the effect of rd_i and err_clr_i.
- R4: While sleep is on, a character with flag 1 clears wake_o and is then handled as in R2, R6 and R7, so a free buffer receives it with mpb_o=1.
- R5: irq_o is high exactly when rie_i and full_o are both high.
- R6: A loaded character whose stop bit is sampled low sets fer_o. The data is still loaded.
- R7: A character that completes while full_o is set and rd_i is low sets ore_o and leaves data_o and mpb_o unchanged. If rd_i is high on the completing edge, the character loads and no overrun is flagged.
- R8: A one-cycle rd_i pulse clears full_o. A one-cycle err_clr_i pulse clears fer_o and ore_o.
- R9: A low pulse that is high again at the start-bit check produces no character. With tick_i low, the line is not sampled.
- R10: A wake_set_i pulse sets wake_o, and wake_o stays set until an address character arrives.
- R11: After reset, data_o is 0 and every flag output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rx_i | input | 1 | Serial line, idle high |
| tick_i | input | 1 | Oversampling tick, 16 per bit |
| len8_i | input | 1 | 1: 8 data bits, 0: 7 data bits |
| wake_set_i | input | 1 | Pulse that arms sleep mode |
| rie_i | input | 1 | Receive interrupt enable |
| rd_i | input | 1 | Buffer read strobe, clears full |
| err_clr_i | input | 1 | Clears framing and overrun flags |
| data_o | output | DATA_W | Receive buffer |
| mpb_o | output | 1 | Flag bit of the buffered character |
| full_o | output | 1 | Receive buffer full |
| fer_o | output | 1 | Framing error |
| ore_o | output | 1 | Overrun error |
| wake_o | output | 1 | Sleep mode active |
| irq_o | output | 1 | Receive interrupt request |

## Verification
The assertions check several rules on every cycle. A data character that completes in sleep mode leaves the buffer and the error flags untouched. An address character ends sleep. An overrun keeps the old buffer. full_o rises only on a completed character, and characters complete only on a tick. Which bits are sampled, and where they land, can only be shown by the bench's scenarios. These cover bit order, 7-bit alignment, exact completion timing, framing errors, a read on the completing edge, rejection of glitches, and stalls while the tick is low. The bench's model predicts every output on every clock.

// File: rtl/mprx_pkg.sv
package mprx_pkg;
    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_START = 3'd1,
        S_DATA  = 3'd2,
        S_FLAG  = 3'd3,
        S_STOP  = 3'd4
    } rx_state_t;
endpackage

// File: rtl/mprx_sampler.sv
module mprx_sampler
    import mprx_pkg::*;
#(
    parameter int OSR = 16,
    parameter int DW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_i,
    input  logic          tick_i,
    input  logic          len_full_i,
    output logic          done_o,
    output logic [DW-1:0] data_o,
    output logic          flag_o,
    output logic          stop_ok_o
);
    localparam int CW = $clog2(OSR);
    localparam int BW = $clog2(DW);
    localparam logic [CW-1:0] HALF = CW'(OSR / 2 - 1);
    localparam logic [CW-1:0] LAST = CW'(OSR - 1);

    typedef struct packed {
        rx_state_t     st;
        logic [1:0]    sync;
        logic [CW-1:0] cnt;
        logic [BW-1:0] idx;
        logic [DW-1:0] sh;
        logic          flag;
        logic          stop_ok;
        logic          done;
    } smp_t;

    smp_t          s_d, s_q;
    logic          rx_s;
    logic [BW-1:0] last_idx;

    assign rx_s     = s_q.sync[1];
    assign last_idx = len_full_i ? BW'(DW - 1) : BW'(DW - 2);

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        s_d.sync = {s_q.sync[0], rx_i};
        if (tick_i) begin
            case (s_q.st)
                S_IDLE: begin
                    if (!rx_s) begin
                        s_d.st  = S_START;
                        s_d.cnt = '0;
                    end
                end
                S_START: begin
                    if (s_q.cnt == HALF) begin
                        s_d.cnt = '0;
                        s_d.idx = '0;
                        s_d.st  = rx_s ? S_IDLE : S_DATA;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                S_DATA: begin
                    if (s_q.cnt == LAST) begin
                        s_d.cnt = '0;
                        s_d.sh  = {rx_s, s_q.sh[DW-1:1]};
                        if (s_q.idx == last_idx) s_d.st = S_FLAG;
                        else                     s_d.idx = s_q.idx + 1'b1;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                S_FLAG: begin
                    if (s_q.cnt == LAST) begin
                        s_d.cnt  = '0;
                        s_d.flag = rx_s;
                        s_d.st   = S_STOP;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                S_STOP: begin
                    if (s_q.cnt == LAST) begin
                        s_d.cnt     = '0;
                        s_d.stop_ok = rx_s;
                        s_d.done    = 1'b1;
                        s_d.st      = S_IDLE;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                default: s_d.st = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.sync <= 2'b11;
        end else begin
            s_q <= s_d;
        end
    end

    assign done_o    = s_q.done;
    assign data_o    = len_full_i ? s_q.sh : (s_q.sh >> 1);
    assign flag_o    = s_q.flag;
    assign stop_ok_o = s_q.stop_ok;
endmodule

// File: rtl/mprx_buffer.sv
module mprx_buffer #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          done_i,
    input  logic [DW-1:0] data_i,
    input  logic          flag_i,
    input  logic          stop_ok_i,
    input  logic          rd_i,
    input  logic          err_clr_i,
    input  logic          wake_set_i,
    output logic [DW-1:0] data_o,
    output logic          mpb_o,
    output logic          full_o,
    output logic          fer_o,
    output logic          ore_o,
    output logic          wake_o
);
    typedef struct packed {
        logic [DW-1:0] data;
        logic          mpb;
        logic          full;
        logic          fer;
        logic          ore;
        logic          wake;
    } buf_t;

    buf_t b_d, b_q;
    logic full_eff;
    logic accept;

    assign full_eff = b_q.full & ~rd_i;
    assign accept   = done_i & ~(b_q.wake & ~flag_i);

    always_comb begin
        b_d      = b_q;
        b_d.full = full_eff;
        if (err_clr_i) begin
            b_d.fer = 1'b0;
            b_d.ore = 1'b0;
        end
        if (accept) begin
            b_d.wake = 1'b0;
            if (full_eff) begin
                b_d.ore = 1'b1;
            end else begin
                b_d.data = data_i;
                b_d.mpb  = flag_i;
                b_d.full = 1'b1;
                if (!stop_ok_i) b_d.fer = 1'b1;
            end
        end
        if (wake_set_i) b_d.wake = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

    assign data_o = b_q.data;
    assign mpb_o  = b_q.mpb;
    assign full_o = b_q.full;
    assign fer_o  = b_q.fer;
    assign ore_o  = b_q.ore;
    assign wake_o = b_q.wake;
endmodule

// File: rtl/mpuart_rx.sv
module mpuart_rx #(
    parameter int OSR    = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_i,
    input  logic              tick_i,
    input  logic              len8_i,
    input  logic              wake_set_i,
    input  logic              rie_i,
    input  logic              rd_i,
    input  logic              err_clr_i,
    output logic [DATA_W-1:0] data_o,
    output logic              mpb_o,
    output logic              full_o,
    output logic              fer_o,
    output logic              ore_o,
    output logic              wake_o,
    output logic              irq_o
);
    logic              smp_done;
    logic [DATA_W-1:0] smp_data;
    logic              smp_flag;
    logic              smp_stop_ok;

    mprx_sampler #(.OSR(OSR), .DW(DATA_W)) u_sampler (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_i       (rx_i),
        .tick_i     (tick_i),
        .len_full_i (len8_i),
        .done_o     (smp_done),
        .data_o     (smp_data),
        .flag_o     (smp_flag),
        .stop_ok_o  (smp_stop_ok)
    );

    mprx_buffer #(.DW(DATA_W)) u_buffer (
        .clk        (clk),
        .rst_n      (rst_n),
        .done_i     (smp_done),
        .data_i     (smp_data),
        .flag_i     (smp_flag),
        .stop_ok_i  (smp_stop_ok),
        .rd_i       (rd_i),
        .err_clr_i  (err_clr_i),
        .wake_set_i (wake_set_i),
        .data_o     (data_o),
        .mpb_o      (mpb_o),
        .full_o     (full_o),
        .fer_o      (fer_o),
        .ore_o      (ore_o),
        .wake_o     (wake_o)
    );

    assign irq_o = rie_i & full_o;
endmodule

// File: rtl/mprx_chk.sv
module mprx_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          done,
    input logic          flag,
    input logic          tick_i,
    input logic          wake_set_i,
    input logic          rd_i,
    input logic          err_clr_i,
    input logic [DW-1:0] data_o,
    input logic          mpb_o,
    input logic          full_o,
    input logic          fer_o,
    input logic          ore_o,
    input logic          wake_o
);
    AST_ASLEEP_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o && done && !flag |=> $stable(data_o) && $stable(mpb_o)); // R3
    AST_ASLEEP_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o && done && !flag && !err_clr_i |=> $stable(fer_o) && $stable(ore_o)); // R3
    AST_ASLEEP_NO_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o && done && !flag && !full_o |=> !full_o); // R3
    AST_ADDR_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o && done && flag && !wake_set_i && !full_o |=> !wake_o && full_o && mpb_o); // R4
    AST_OVERRUN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        done && full_o && !rd_i && (!wake_o || flag) |=> ore_o && $stable(data_o)); // R7
    AST_FULL_FROM_CHAR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full_o) |-> $past(done)); // R2
    AST_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_i && !done |=> !full_o); // R8
    AST_DONE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(tick_i)); // R9
endmodule

bind mpuart_rx mprx_chk #(.DW(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .done       (smp_done),
    .flag       (smp_flag),
    .tick_i     (tick_i),
    .wake_set_i (wake_set_i),
    .rd_i       (rd_i),
    .err_clr_i  (err_clr_i),
    .data_o     (data_o),
    .mpb_o      (mpb_o),
    .full_o     (full_o),
    .fer_o      (fer_o),
    .ore_o      (ore_o),
    .wake_o     (wake_o)
);

// File: tb/mpuart_rx_test.sv
`timescale 1ns/1ps
module mpuart_rx_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx = 1'b1;
    logic       tick = 1'b1;
    logic       len8 = 1'b1;
    logic       wake_set = 1'b0;
    logic       rie = 1'b1;
    logic       rd = 1'b0;
    logic       err_clr = 1'b0;
    logic [7:0] data_o;
    logic       mpb_o, full_o, fer_o, ore_o, wake_o, irq_o;

    int  checks = 0;
    int  errors = 0;
    bit  done_flag = 1'b0;

    logic [7:0] m_data = '0;
    bit m_mpb = 0, m_full = 0, m_fer = 0, m_ore = 0, m_wake = 0;

    always #2 clk = ~clk;

    mpuart_rx uut (
        .clk(clk), .rst_n(rst_n), .rx_i(rx), .tick_i(tick), .len8_i(len8),
        .wake_set_i(wake_set), .rie_i(rie), .rd_i(rd), .err_clr_i(err_clr),
        .data_o(data_o), .mpb_o(mpb_o), .full_o(full_o), .fer_o(fer_o),
        .ore_o(ore_o), .wake_o(wake_o), .irq_o(irq_o)
    );

    task automatic check1(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // per-clock comparison against the behavioural model
    always @(posedge clk) begin
        #1;
        if (rst_n && !done_flag) begin
            check1("R2", "data_o", data_o, m_data);
            check1("R2", "mpb_o", mpb_o, m_mpb);
            check1("R2", "full_o", full_o, m_full);
            check1("R6", "fer_o", fer_o, m_fer);
            check1("R7", "ore_o", ore_o, m_ore);
            check1("R10", "wake_o", wake_o, m_wake);
            check1("R5", "irq_o", irq_o, rie && m_full);
        end
    end

    function automatic void model_char(input logic [7:0] d, input bit m, input bit s, input bit rdx);
        bit fe;
        fe = m_full && !rdx;
        m_full = fe;
        if (m_wake && !m) return;
        m_wake = 0;
        if (fe) m_ore = 1;
        else begin
            m_data = len8 ? d : {1'b0, d[6:0]};
            m_mpb  = m;
            m_full = 1;
            if (!s) m_fer = 1;
        end
    endfunction

    task automatic send(input logic [7:0] d, input bit m, input bit s, input bit rd_end);
        int n;
        n = len8 ? 8 : 7;
        @(negedge clk);
        rx = 1'b0;
        fork
            begin
                repeat (16) @(negedge clk);
                for (int i = 0; i < n; i++) begin
                    rx = d[i];
                    repeat (16) @(negedge clk);
                end
                rx = m;
                repeat (16) @(negedge clk);
                rx = s;
                repeat (16) @(negedge clk);
                rx = 1'b1;
            end
            begin
                if (rd_end) begin
                    repeat (16 * n + 43) @(posedge clk);
                    @(negedge clk) rd = 1'b1;
                    @(posedge clk) model_char(d, m, s, 1'b1);
                    @(negedge clk) rd = 1'b0;
                end else begin
                    repeat (16 * n + 44) @(posedge clk);
                    model_char(d, m, s, 1'b0);
                end
            end
        join
        repeat (20) @(negedge clk);
    endtask

    task automatic pulse_rd();
        @(negedge clk) rd = 1'b1;
        @(posedge clk) m_full = 0;
        @(negedge clk) rd = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk) err_clr = 1'b1;
        @(posedge clk) begin m_fer = 0; m_ore = 0; end
        @(negedge clk) err_clr = 1'b0;
    endtask

    task automatic pulse_wake();
        @(negedge clk) wake_set = 1'b1;
        @(posedge clk) m_wake = 1;
        @(negedge clk) wake_set = 1'b0;
    endtask

    task automatic finish_run();
        done_flag = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            errors++;
            $display("FAIL watchdog: run did not complete");
            finish_run();
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check1("R11", "reset data", data_o, 0);
        check1("R11", "reset flags", {mpb_o, full_o, fer_o, ore_o, wake_o, irq_o}, 0);

        // R1 R2: plain data character, LSB first
        send(8'hA5, 1'b0, 1'b1, 1'b0);
        check1("R1", "8-bit data", data_o, 8'hA5);
        check1("R2", "full after load", full_o, 1);
        check1("R5", "irq with rie", irq_o, 1);
        pulse_rd();
        check1("R8", "read clears full", full_o, 0);

        // R2: address character in normal mode
        send(8'h3C, 1'b1, 1'b1, 1'b0);
        check1("R2", "mpb latched", mpb_o, 1);

        // R7: overrun keeps buffer
        send(8'h77, 1'b0, 1'b1, 1'b0);
        check1("R7", "overrun flag", ore_o, 1);
        check1("R7", "buffer kept", data_o, 8'h3C);
        pulse_clr();
        check1("R8", "clear ore", ore_o, 0);
        pulse_rd();

        // R6: framing error
        send(8'h12, 1'b0, 1'b0, 1'b0);
        check1("R6", "framing flag", fer_o, 1);
        check1("R6", "data still loaded", data_o, 8'h12);
        pulse_clr();
        pulse_rd();

        // R7: read on the completing edge avoids overrun
        send(8'h40, 1'b0, 1'b1, 1'b0);
        send(8'h41, 1'b0, 1'b1, 1'b1);
        check1("R7", "no overrun with read", ore_o, 0);
        check1("R7", "new char loaded", data_o, 8'h41);
        pulse_rd();

        // R10 R3 R4: sleep mode
        pulse_wake();
        check1("R10", "wake set", wake_o, 1);
        send(8'h55, 1'b0, 1'b1, 1'b0);
        check1("R3", "data char discarded", full_o, 0);
        check1("R3", "buffer untouched", data_o, 8'h41);
        send(8'h66, 1'b0, 1'b0, 1'b0);
        check1("R3", "no framing in sleep", fer_o, 0);
        check1("R10", "still asleep", wake_o, 1);
        send(8'h09, 1'b1, 1'b1, 1'b0);
        check1("R4", "wake cleared", wake_o, 0);
        check1("R4", "address loaded", data_o, 8'h09);
        check1("R4", "address flag", mpb_o, 1);
        check1("R5", "irq on resume", irq_o, 1);
        pulse_rd();
        send(8'h88, 1'b0, 1'b1, 1'b0);
        check1("R2", "data after wake", data_o, 8'h88);

        // R3: sleep with a full buffer raises no overrun
        pulse_wake();
        send(8'h99, 1'b0, 1'b1, 1'b0);
        check1("R3", "no overrun asleep", ore_o, 0);
        pulse_rd();
        send(8'hE1, 1'b1, 1'b1, 1'b0);
        check1("R4", "address after sleep", data_o, 8'hE1);
        pulse_rd();

        // R1: 7-bit mode
        len8 = 1'b0;
        send(8'hFF, 1'b0, 1'b1, 1'b0);
        check1("R1", "7-bit data", data_o, 8'h7F);
        check1("R1", "7-bit flag", mpb_o, 0);
        pulse_rd();
        send(8'h05, 1'b1, 1'b1, 1'b0);
        check1("R1", "7-bit address flag", mpb_o, 1);
        check1("R1", "7-bit address data", data_o, 8'h05);
        pulse_rd();
        len8 = 1'b1;

        // R9: glitch rejection
        @(negedge clk) rx = 1'b0;
        repeat (4) @(negedge clk);
        rx = 1'b1;
        repeat (60) @(negedge clk);
        check1("R9", "glitch ignored", full_o, 0);

        // R9: no sampling without tick
        tick = 1'b0;
        rx = 1'b0;
        repeat (200) @(negedge clk);
        rx = 1'b1;
        repeat (10) @(negedge clk);
        tick = 1'b1;
        repeat (40) @(negedge clk);
        check1("R9", "tick gated", full_o, 0);

        // R5: interrupt disabled
        send(8'h21, 1'b0, 1'b1, 1'b0);
        rie = 1'b0;
        @(negedge clk);
        check1("R5", "irq masked", irq_o, 0);

        finish_run();
    end
endmodule